// File: doc/BRIEF.md
# Programmable Voltage–Current Phase Aligner

This block fixes the phase error that an external current or voltage transducer adds to a sampled measurement. It does this by shifting one stream of each voltage/current pair against the other by a whole number of sample periods. A step is one sample period of the sample strobe; at a 1.024 MHz sample rate that is about 0.976 µs. There are three phase lanes, and every lane takes its voltage and current samples on one shared sample strobe. Each lane produces an aligned pair one clock after the strobe.

Each lane has a 10-bit calibration code, reached through a small register port.

- **Voltage delay.** When bit 9 of the code is set, the voltage stream is delayed by the magnitude in bits 8:0. At most 63 steps are allowed.
- **Voltage advance.** When bit 9 is clear, the code requests a voltage advance of bits 8:0 steps, up to 383. An advance cannot be produced causally. The lane therefore delays the current stream by that many samples instead, and the voltage stream passes through undelayed.
- **Out-of-range codes.** Codes outside these ranges are clamped to the nearest limit and latch a per-lane error flag.
- **Output qualification.** After reset, or after a write to a lane's code, that lane marks its outputs invalid until its delay memory holds enough new samples.

Top module: `phase_aligner`

## Requirements
- R1: Lanes 0, 1 and 2 are at register addresses 0, 1 and 2. A write stores `reg_wdata[9:0]` and ignores bits 15:10. A read returns the stored code in bits 9:0 with bits 15:10 zero. Address 3 reads as zero. All codes are zero after reset.
- R2: With a code of zero, the `v_out` and `i_out` lane slices equal the samples taken at the previous strobe. `out_stb` is high exactly in the clock after each strobe.
- R3: A code with bit 9 set and a magnitude N ≤ 63 in bits 8:0 makes the lane's `v_out` the voltage sample from N strobes earlier. The lane's `i_out` is the current sample of the same strobe.
- R4: A code with bit 9 clear and a magnitude N ≤ 383 makes the lane's `i_out` the current sample from N strobes earlier. The lane's `v_out` is the voltage sample of the same strobe.
- R5: A code with bit 9 set and a magnitude above 63 acts as a voltage delay of 63. It also sets that lane's bit of `range_err`.
- R6: A code with bit 9 clear and a magnitude above 383 acts as a current delay of 383. It also sets that lane's bit of `range_err`.
- R7: A `range_err` bit, once set, stays set until reset. Later in-range writes do not clear it.
- R8: After reset or a write to a lane, that lane's `out_ok` bit is low for the outputs of the first D strobes, where D is the applied delay. It is high from strobe D on, and it falls in the clock after the write.
- R9: A write to one lane changes neither the data nor the `out_ok` of the other lanes.
- R10: In a clock with no strobe, `v_out` and `i_out` hold their values and `out_stb` is low.
- R11: During reset, `out_stb`, `out_ok`, `range_err`, `v_out` and `i_out` all go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe shared by all lanes |
| v_in | input | LANES*SAMPLE_W | Voltage samples, lane k in slice k |
| i_in | input | LANES*SAMPLE_W | Current samples, lane k in slice k |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (lane number) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| v_out | output | LANES*SAMPLE_W | Aligned voltage samples |
| i_out | output | LANES*SAMPLE_W | Aligned current samples |
| out_stb | output | 1 | High for one clock when new outputs are present |
| out_ok | output | LANES | Per-lane output valid |
| range_err | output | LANES | Per-lane sticky out-of-range flag |

## Verification
Every aligned pair and its `out_ok` bits appear one clock after the strobe that produced them. The driver queues the expected pair at the moment it raises the strobe. The monitor pops that entry only when it sees `out_stb` high, so each result is compared in the clock it is due, with no fixed latency assumed in the bench.

Register reads are combinational, so they are checked shortly after the address changes. Error flags are checked in the clock after the write. Expected delayed samples come from the bench's own history of every sample it drove, indexed by strobe count and the delay the bench decodes itself.

// File: rtl/phalign_pkg.sv
package phalign_pkg;

    localparam int PA_CODE_W = 10;
    localparam int PA_REG_W  = 16;
    localparam int PA_MAG_W  = PA_CODE_W - 1;
    localparam int PA_V_MAX  = 63;
    localparam int PA_I_MAX  = 383;
    localparam int PA_V_AW   = $clog2(PA_V_MAX + 1);
    localparam int PA_I_AW   = $clog2(PA_I_MAX + 1);

    typedef logic [PA_CODE_W-1:0] pa_code_t;

    // Decoded lane setting: which path is delayed and by how many samples
    typedef struct packed {
        logic                v_path;   // 1: voltage delayed, 0: current delayed
        logic [PA_MAG_W-1:0] depth;    // applied delay in samples
        logic                oor;      // code was out of range (clamped)
    } pa_cfg_t;

    function automatic pa_cfg_t pa_decode(pa_code_t code);
        pa_cfg_t             c;
        logic [PA_MAG_W-1:0] mag;
        mag      = code[PA_MAG_W-1:0];
        c.v_path = code[PA_CODE_W-1];
        c.oor    = 1'b0;
        c.depth  = mag;
        if (c.v_path) begin
            if (mag > PA_MAG_W'(PA_V_MAX)) begin
                c.depth = PA_MAG_W'(PA_V_MAX);
                c.oor   = 1'b1;
            end
        end else begin
            if (mag > PA_MAG_W'(PA_I_MAX)) begin
                c.depth = PA_MAG_W'(PA_I_MAX);
                c.oor   = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/pa_cfg_regs.sv
module pa_cfg_regs
    import phalign_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [PA_REG_W-1:0] reg_wdata,
    output logic [PA_REG_W-1:0] reg_rdata,
    output pa_cfg_t             cfg [LANES],
    output logic [LANES-1:0]    wr_hit,
    output logic [LANES-1:0]    range_err
);

    pa_code_t code_q [LANES];
    pa_cfg_t  wr_dec;

    assign wr_dec = pa_decode(reg_wdata[PA_CODE_W-1:0]);

    wire unused_hi = &{1'b0, reg_wdata[PA_REG_W-1:PA_CODE_W]};

    for (genvar k = 0; k < LANES; k++) begin : g_lane_reg
        assign wr_hit[k] = reg_we && (reg_addr == 2'(k));
        assign cfg[k]    = pa_decode(code_q[k]);

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[k]    <= '0;
                range_err[k] <= 1'b0;
            end else if (wr_hit[k]) begin
                code_q[k]    <= reg_wdata[PA_CODE_W-1:0];
                range_err[k] <= range_err[k] | wr_dec.oor;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (reg_addr == 2'(k)) begin
                reg_rdata = {{(PA_REG_W-PA_CODE_W){1'b0}}, code_q[k]};
            end
        end
    end

endmodule

// File: rtl/pa_delay_line.sv
module pa_delay_line #(
    parameter int W  = 24,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] dly,
    output logic [W-1:0]  dout
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] raddr;

    assign raddr = wptr - dly;

    always_ff @(posedge clk) begin
        if (stb) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            dout <= '0;
        end else if (stb) begin
            wptr <= wptr + 1'b1;
            dout <= (dly == '0) ? din : mem[raddr];
        end
    end

endmodule

// File: rtl/pa_lane.sv
module pa_lane
    import phalign_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                cfg_wr,
    input  pa_cfg_t             cfg,
    input  logic [SAMPLE_W-1:0] v_in,
    input  logic [SAMPLE_W-1:0] i_in,
    output logic [SAMPLE_W-1:0] v_out,
    output logic [SAMPLE_W-1:0] i_out,
    output logic                ok
);

    logic [PA_V_AW-1:0]  v_dly;
    logic [PA_I_AW-1:0]  i_dly;
    logic [PA_MAG_W-1:0] fill;

    assign v_dly = cfg.v_path ? cfg.depth[PA_V_AW-1:0] : '0;
    assign i_dly = cfg.v_path ? '0 : cfg.depth[PA_I_AW-1:0];

    pa_delay_line #(.W(SAMPLE_W), .AW(PA_V_AW)) u_vline (
        .clk (clk),
        .rst (rst),
        .stb (stb),
        .din (v_in),
        .dly (v_dly),
        .dout(v_out)
    );

    pa_delay_line #(.W(SAMPLE_W), .AW(PA_I_AW)) u_iline (
        .clk (clk),
        .rst (rst),
        .stb (stb),
        .din (i_in),
        .dly (i_dly),
        .dout(i_out)
    );

    // Count strobes since reset or the last code write
    always_ff @(posedge clk) begin
        if (rst || cfg_wr) begin
            fill <= '0;
            ok   <= 1'b0;
        end else if (stb) begin
            ok <= (fill >= cfg.depth);
            if (fill != '1) begin
                fill <= fill + 1'b1;
            end
        end
    end

endmodule

// File: rtl/phase_aligner.sv
module phase_aligner
    import phalign_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int LANES    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_stb,
    input  logic [LANES*SAMPLE_W-1:0] v_in,
    input  logic [LANES*SAMPLE_W-1:0] i_in,
    input  logic                      reg_we,
    input  logic [1:0]                reg_addr,
    input  logic [15:0]               reg_wdata,
    output logic [15:0]               reg_rdata,
    output logic [LANES*SAMPLE_W-1:0] v_out,
    output logic [LANES*SAMPLE_W-1:0] i_out,
    output logic                      out_stb,
    output logic [LANES-1:0]          out_ok,
    output logic [LANES-1:0]          range_err
);

    pa_cfg_t          cfg [LANES];
    logic [LANES-1:0] wr_hit;

    pa_cfg_regs #(.LANES(LANES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg      (cfg),
        .wr_hit   (wr_hit),
        .range_err(range_err)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pa_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .stb   (smp_stb),
            .cfg_wr(wr_hit[k]),
            .cfg   (cfg[k]),
            .v_in  (v_in[k*SAMPLE_W +: SAMPLE_W]),
            .i_in  (i_in[k*SAMPLE_W +: SAMPLE_W]),
            .v_out (v_out[k*SAMPLE_W +: SAMPLE_W]),
            .i_out (i_out[k*SAMPLE_W +: SAMPLE_W]),
            .ok    (out_ok[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_stb <= 1'b0;
        end else begin
            out_stb <= smp_stb;
        end
    end

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int SAMPLE_W = 24,
    parameter int LANES    = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      smp_stb,
    input logic                      reg_we,
    input logic [1:0]                reg_addr,
    input logic [15:0]               reg_rdata,
    input logic [LANES*SAMPLE_W-1:0] v_out,
    input logic [LANES*SAMPLE_W-1:0] i_out,
    input logic                      out_stb,
    input logic [LANES-1:0]          out_ok,
    input logic [LANES-1:0]          range_err
);

    // R1
    rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15:10] == 6'd0);

    // R2
    stb_follows_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> out_stb);

    // R10
    idle_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> !out_stb);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(v_out) && $stable(i_out)));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((range_err & $past(range_err)) == $past(range_err)));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_ok == '0 && range_err == '0 && !out_stb));

    for (genvar k = 0; k < LANES; k++) begin : g_wr
        // R8
        wr_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == 2'(k)) |=> !out_ok[k]);
    end

endmodule

bind phase_aligner pa_checker #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .v_out    (v_out),
    .i_out    (i_out),
    .out_stb  (out_stb),
    .out_ok   (out_ok),
    .range_err(range_err)
);

// File: tb/tb_phase_aligner.sv
module tb_phase_aligner;

    localparam int SW  = 24;
    localparam int NL  = 3;
    localparam int HIS = 1024;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_stb = 1'b0;
    logic [NL*SW-1:0] v_in = '0;
    logic [NL*SW-1:0] i_in = '0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic [NL*SW-1:0] v_out;
    logic [NL*SW-1:0] i_out;
    logic             out_stb;
    logic [NL-1:0]    out_ok;
    logic [NL-1:0]    range_err;

    always #5 clk = ~clk;

    phase_aligner #(.SAMPLE_W(SW), .LANES(NL)) dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .v_in(v_in), .i_in(i_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .v_out(v_out), .i_out(i_out),
        .out_stb(out_stb), .out_ok(out_ok), .range_err(range_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic [SW-1:0] vh [NL][HIS];
    logic [SW-1:0] ih [NL][HIS];
    int            nsmp = 0;
    int            since [NL];
    int            m_dly [NL];
    bit            m_vp  [NL];
    int            m_mode [NL];
    logic [NL-1:0] m_err = '0;

    typedef struct {
        logic [NL*SW-1:0] v;
        logic [NL*SW-1:0] i;
        logic [NL-1:0]    ok;
        int               mode [NL];
    } exp_t;

    exp_t exp_q [$];

    function automatic string mtag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit cond, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic wr_reg(int lane, logic [15:0] d);
        int  mag;
        bit  vp;
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 2'(lane);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        vp  = d[9];
        mag = int'(d[8:0]);
        since[lane] = 0;
        m_vp[lane]  = vp;
        if (vp) begin
            if (mag > 63) begin m_dly[lane] = 63; m_err[lane] = 1'b1; m_mode[lane] = 3; end
            else begin m_dly[lane] = mag; m_mode[lane] = (mag == 0) ? 0 : 1; end
        end else begin
            if (mag > 383) begin m_dly[lane] = 383; m_err[lane] = 1'b1; m_mode[lane] = 4; end
            else begin m_dly[lane] = mag; m_mode[lane] = (mag == 0) ? 0 : 2; end
        end
        // R8: lane invalid right after the write
        check(out_ok[lane] == 1'b0, "R8", "out_ok after write", out_ok[lane], 0);
    endtask

    task automatic rd_chk(int a, logic [15:0] expv, string tag);
        @(negedge clk);
        reg_addr = 2'(a);
        #1;
        check(reg_rdata == expv, tag, "reg_rdata", reg_rdata, expv);
    endtask

    task automatic burst(int n, bit gaps);
        for (int s = 0; s < n; s++) begin
            exp_t e;
            @(negedge clk);
            smp_stb = 1'b1;
            for (int k = 0; k < NL; k++) begin
                int src;
                vh[k][nsmp] = SW'($urandom);
                ih[k][nsmp] = SW'($urandom);
                v_in[k*SW +: SW] = vh[k][nsmp];
                i_in[k*SW +: SW] = ih[k][nsmp];
                src = nsmp - m_dly[k];
                if (src < 0) src = 0;
                e.v[k*SW +: SW] = m_vp[k] ? vh[k][src] : vh[k][nsmp];
                e.i[k*SW +: SW] = m_vp[k] ? ih[k][nsmp] : ih[k][src];
                e.ok[k]   = (since[k] >= m_dly[k]);
                e.mode[k] = m_mode[k];
                since[k]++;
            end
            exp_q.push_back(e);
            nsmp++;
            if (gaps && (s % 3 == 2)) begin
                @(negedge clk);
                smp_stb = 1'b0;
            end
        end
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_stb", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                for (int k = 0; k < NL; k++) begin
                    // R8, R9: per-lane valid flag
                    check(out_ok[k] == e.ok[k], "R8", "out_ok", out_ok[k], e.ok[k]);
                    if (e.ok[k]) begin
                        check(v_out[k*SW +: SW] == e.v[k*SW +: SW], mtag(e.mode[k]),
                              "v_out", v_out[k*SW +: SW], e.v[k*SW +: SW]);
                        check(i_out[k*SW +: SW] == e.i[k*SW +: SW], mtag(e.mode[k]),
                              "i_out", i_out[k*SW +: SW], e.i[k*SW +: SW]);
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NL*SW-1:0] hv, hi;
        for (int k = 0; k < NL; k++) begin
            since[k] = 0; m_dly[k] = 0; m_vp[k] = 1'b0; m_mode[k] = 0;
        end
        repeat (4) @(negedge clk);
        // R11: reset state
        check(out_ok == '0, "R11", "out_ok in reset", out_ok, 0);
        check(out_stb == 1'b0, "R11", "out_stb in reset", out_stb, 0);
        check(v_out == '0 && i_out == '0, "R11", "data in reset", v_out[SW-1:0], 0);
        rst = 1'b0;
        check(range_err == '0, "R11", "range_err", range_err, 0);
        for (int a = 0; a < 4; a++) rd_chk(a, 16'h0000, "R1");

        // R2: zero codes pass through
        burst(8, 1'b0);

        // R3, R4, R8, R9: per-lane delays
        wr_reg(0, 16'h0205);
        wr_reg(1, 16'h000A);
        wr_reg(2, 16'h023F);
        rd_chk(0, 16'h0205, "R1");
        rd_chk(1, 16'h000A, "R1");
        rd_chk(2, 16'h023F, "R1");
        burst(80, 1'b1);

        // R1: upper bits ignored; R4 at the 383 limit
        wr_reg(2, 16'hFD7F);
        rd_chk(2, 16'h017F, "R1");
        rd_chk(3, 16'h0000, "R1");
        check(range_err == 3'b000, "R1", "range_err after in-range", range_err, 0);

        // R5, R6: out-of-range codes clamp and flag
        wr_reg(0, 16'h0250);
        check(range_err == 3'b001, "R5", "range_err", range_err, 3'b001);
        wr_reg(1, 16'h01FF);
        check(range_err == 3'b011, "R6", "range_err", range_err, 3'b011);
        burst(400, 1'b0);

        // R7: in-range write keeps flag
        wr_reg(0, 16'h0000);
        check(range_err == m_err, "R7", "range_err sticky", range_err, m_err);
        burst(12, 1'b1);

        // R10: hold without strobe
        hv = v_out;
        hi = i_out;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(out_stb == 1'b0, "R10", "out_stb idle", out_stb, 0);
        end
        check(v_out == hv && i_out == hi, "R10", "outputs held", v_out[SW-1:0], hv[SW-1:0]);
        check(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule